// File: doc/BRIEF.md
# Alarm Match and Interrupt Status Unit

This block sits beside a real-time clock's timekeeping logic. It holds three alarm bytes for seconds, minutes and hours. At the end of each time update it compares them against the current time. It also owns the interrupt status byte, which records three kinds of event: periodic ticks, alarm matches and update completions.

An alarm byte whose two top bits are both set (any value 0xC0 or above) matches every value of its field. Setting one, two or all three alarm bytes this way makes the alarm fire every hour, every minute or every second.

Each recorded event is combined with its own enable input to form the summary interrupt bit and an active-low interrupt request. Software reads the status byte through a small indexed read port, and that read clears every flag. A second read-only index always reports valid RAM and time.

Top module: `rtc_alarm_irq`

## Requirements
- R1: After a synchronous active-low reset, all flags are clear, `irq_n` is 1, `rd_data` is 0x00 and all alarm bytes are 0x00.
- R2: A write to index 1, 3 or 5 stores the seconds, minutes or hours alarm byte respectively, and a read of that index returns it. A write to any other index changes no state.
- R3: When `upd_done` is high and all three fields match, the alarm flag (AF) is set at that clock edge.
- R4: An alarm byte with bits 7:6 equal to 2'b11 matches any value of its time field.
- R5: AF is set only in a cycle with `upd_done` high and a full match. A mismatch in any one field, or a match without `upd_done`, leaves AF clear.
- R6: `upd_done` sets UF and `per_tick` sets PF. Both flags latch regardless of the enable inputs.
- R7: A read at index 12 (0x0C) returns the status byte on `rd_data` one cycle after `rd_en`. Bit 7 is the summary bit (IRQF), bit 6 is PF, bit 5 is AF, bit 4 is UF, and bits 3:0 are 0. `rd_data` holds its value when there is no read.
- R8: A status read clears PF, AF and UF. An event arriving in the same cycle as the read leaves its flag set.
- R9: IRQF = (PF & `en_per`) | (AF & `en_alm`) | (UF & `en_upd`), and `irq_n` is its inverse at all times.
- R10: A read at index 13 returns 0x80. A read at any index not named in R2, R7 or R10 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cur_sec | input | 8 | Current seconds value |
| cur_min | input | 8 | Current minutes value |
| cur_hour | input | 8 | Current hours value |
| upd_done | input | 1 | One-cycle pulse at the end of a time update |
| per_tick | input | 1 | One-cycle periodic event pulse |
| en_per | input | 1 | Periodic interrupt enable |
| en_alm | input | 1 | Alarm interrupt enable |
| en_upd | input | 1 | Update-ended interrupt enable |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 6 | Register write index |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_idx | input | 6 | Register read index |
| rd_data | output | 8 | Registered read data |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench targets wildcard bytes on one or two fields while a third field is either matched or mismatched. A compare that tested only the top bit, or that treated a wildcard as a mismatch, would set AF in the wrong cases. It also places an update event in the very cycle of a status read: a design that gave the clear priority would lose UF, and the following read would show 0x00 instead of 0x90. Enables are switched while flags are already held, to confirm that PF, AF and UF latch independently and that `irq_n` follows the enables combinationally. Writes to unmapped indices must leave the alarm bytes and the status byte untouched.

// File: rtl/rtc_alarm_irq_pkg.sv
// Package: shared constants and helpers for the alarm/interrupt unit.
// Assumes 8-bit register bytes and a 6-bit register index space.
package rtc_alarm_irq_pkg;

    localparam int unsigned REG_W     = 8;
    localparam int unsigned IDX_W     = 6;
    localparam int unsigned N_FIELDS  = 3;
    localparam int unsigned IDX_STAT  = 12;
    localparam int unsigned IDX_VALID = 13;

    // Index of alarm field f (seconds, minutes, hours) in register space
    function automatic int unsigned alarm_index(input int unsigned f);
        return 2 * f + 1;
    endfunction

    // A byte whose two top bits are set matches every value of its field
    function automatic logic is_wild(input logic [REG_W-1:0] b);
        return b[REG_W-1] & b[REG_W-2];
    endfunction

endpackage

// File: rtl/rtc_alarm_bank.sv
// Module: stores one alarm byte per time field and serves its readback.
// Assumes field f lives at register index 2*f+1; other indices are ignored.
module rtc_alarm_bank #(
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned ADDR_W  = 6,
    parameter int unsigned FIELDS  = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_idx,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic [ADDR_W-1:0]             rd_idx,
    output logic [FIELDS-1:0][DATA_W-1:0] alarms,
    output logic                          rd_hit,
    output logic [DATA_W-1:0]             rd_val
);
    import rtc_alarm_irq_pkg::*;

    genvar g;
    generate
        for (g = 0; g < FIELDS; g++) begin : g_field
            localparam logic [ADDR_W-1:0] MY_IDX = ADDR_W'(alarm_index(g));
            // Purpose: capture a write addressed to this field's index
            always_ff @(posedge clk) begin
                if (!rst_n)
                    alarms[g] <= '0;
                else if (wr_en && (wr_idx == MY_IDX))
                    alarms[g] <= wr_data;
            end
        end
    endgenerate

    // Purpose: select the addressed alarm byte for readback
    always_comb begin
        rd_hit = 1'b0;
        rd_val = '0;
        for (int f = 0; f < FIELDS; f++) begin
            if (rd_idx == ADDR_W'(alarm_index(f))) begin
                rd_hit = 1'b1;
                rd_val = alarms[f];
            end
        end
    end

endmodule

// File: rtl/rtc_alarm_match.sv
// Module: per-field compare of current time against the alarm bytes.
// Assumes a wildcard byte (top two bits set) matches any value.
module rtc_alarm_match #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned FIELDS = 3
) (
    input  logic [FIELDS-1:0][DATA_W-1:0] now_val,
    input  logic [FIELDS-1:0][DATA_W-1:0] alarms,
    output logic                          all_match
);
    import rtc_alarm_irq_pkg::*;

    logic [FIELDS-1:0] field_ok;

    genvar g;
    generate
        for (g = 0; g < FIELDS; g++) begin : g_cmp
            // Purpose: one field matches on equality or wildcard
            assign field_ok[g] = is_wild(alarms[g]) || (alarms[g] == now_val[g]);
        end
    endgenerate

    assign all_match = &field_ok;

endmodule

// File: rtl/rtc_irq_flags.sv
// Module: latches periodic, alarm and update-ended flags and forms the
// summary bit and status byte. Assumes events win over a same-cycle clear.
module rtc_irq_flags #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_done,
    input  logic              per_tick,
    input  logic              alarm_hit,
    input  logic              status_rd,
    input  logic              en_per,
    input  logic              en_alm,
    input  logic              en_upd,
    output logic              pf_q,
    output logic              af_q,
    output logic              uf_q,
    output logic              irqf,
    output logic [DATA_W-1:0] status_byte
);
    localparam int unsigned PAD_W = DATA_W - 4;

    // Purpose: set flags on events, clear on status read, event has priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf_q <= 1'b0;
            af_q <= 1'b0;
            uf_q <= 1'b0;
        end else begin
            pf_q <= per_tick | (pf_q & ~status_rd);
            af_q <= (upd_done & alarm_hit) | (af_q & ~status_rd);
            uf_q <= upd_done | (uf_q & ~status_rd);
        end
    end

    // Purpose: summary bit from each flag gated by its enable
    assign irqf = (pf_q & en_per) | (af_q & en_alm) | (uf_q & en_upd);

    // Purpose: pack the status byte with the low nibble forced to zero
    assign status_byte = {irqf, pf_q, af_q, uf_q, {PAD_W{1'b0}}};

endmodule

// File: rtl/rtc_alarm_irq.sv
// Module: top of the alarm match and interrupt status unit. Holds the
// registered read mux. Assumes one-cycle event pulses and one read per cycle.
module rtc_alarm_irq #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] cur_sec,
    input  logic [DATA_W-1:0] cur_min,
    input  logic [DATA_W-1:0] cur_hour,
    input  logic              upd_done,
    input  logic              per_tick,
    input  logic              en_per,
    input  logic              en_alm,
    input  logic              en_upd,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_n
);
    import rtc_alarm_irq_pkg::*;

    localparam int unsigned FIELDS = N_FIELDS;
    localparam logic [ADDR_W-1:0] STAT_IDX  = ADDR_W'(IDX_STAT);
    localparam logic [ADDR_W-1:0] VALID_IDX = ADDR_W'(IDX_VALID);
    localparam logic [DATA_W-1:0] VALID_VAL = {1'b1, {(DATA_W-1){1'b0}}};

    logic [FIELDS-1:0][DATA_W-1:0] now_val;
    logic [FIELDS-1:0][DATA_W-1:0] alarms;
    logic                          bank_hit;
    logic [DATA_W-1:0]             bank_val;
    logic                          all_match;
    logic                          status_rd;
    logic                          pf_q, af_q, uf_q, irqf;
    logic [DATA_W-1:0]             status_byte;
    logic [DATA_W-1:0]             rd_next;

    assign now_val   = {cur_hour, cur_min, cur_sec};
    assign status_rd = rd_en && (rd_idx == STAT_IDX);

    rtc_alarm_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .FIELDS(FIELDS)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_idx(rd_idx), .alarms(alarms),
        .rd_hit(bank_hit), .rd_val(bank_val)
    );

    rtc_alarm_match #(.DATA_W(DATA_W), .FIELDS(FIELDS)) u_match (
        .now_val(now_val), .alarms(alarms), .all_match(all_match)
    );

    rtc_irq_flags #(.DATA_W(DATA_W)) u_flags (
        .clk(clk), .rst_n(rst_n), .upd_done(upd_done), .per_tick(per_tick),
        .alarm_hit(all_match), .status_rd(status_rd), .en_per(en_per),
        .en_alm(en_alm), .en_upd(en_upd), .pf_q(pf_q), .af_q(af_q),
        .uf_q(uf_q), .irqf(irqf), .status_byte(status_byte)
    );

    // Purpose: choose the byte addressed by the read index
    always_comb begin
        if (bank_hit)
            rd_next = bank_val;
        else if (rd_idx == STAT_IDX)
            rd_next = status_byte;
        else if (rd_idx == VALID_IDX)
            rd_next = VALID_VAL;
        else
            rd_next = '0;
    end

    // Purpose: register read data on a read strobe, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_en)
            rd_data <= rd_next;
    end

    assign irq_n = ~irqf;

endmodule

// File: rtl/rtc_alarm_irq_chk.sv
// Checker: temporal properties of the alarm/interrupt unit, bound to the top.
module rtc_alarm_irq_chk #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              upd_done,
    input logic              per_tick,
    input logic              en_per,
    input logic              en_alm,
    input logic              en_upd,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_idx,
    input logic [DATA_W-1:0] rd_data,
    input logic              irq_n,
    input logic              pf_q,
    input logic              af_q,
    input logic              uf_q
);
    localparam logic [ADDR_W-1:0] STAT_IDX  = ADDR_W'(12);
    localparam logic [ADDR_W-1:0] VALID_IDX = ADDR_W'(13);

    assert_upd_sets_uf_R6: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done |=> uf_q);

    assert_tick_sets_pf_R6: assert property (@(posedge clk) disable iff (!rst_n)
        per_tick |=> pf_q);

    assert_af_only_on_update_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(af_q) |-> $past(upd_done));

    assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_idx == STAT_IDX && !upd_done && !per_tick) |=> (!pf_q && !af_q && !uf_q));

    assert_low_nibble_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_idx == STAT_IDX) |=> (rd_data[3:0] == 4'h0));

    assert_valid_reads_80_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_idx == VALID_IDX) |=> (rd_data == 8'h80));

    assert_no_enable_no_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_per && !en_alm && !en_upd) |-> irq_n);

    assert_enabled_flag_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((pf_q && en_per) || (uf_q && en_upd)) |-> !irq_n);

endmodule

bind rtc_alarm_irq rtc_alarm_irq_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .upd_done(upd_done), .per_tick(per_tick),
    .en_per(en_per), .en_alm(en_alm), .en_upd(en_upd), .rd_en(rd_en),
    .rd_idx(rd_idx), .rd_data(rd_data), .irq_n(irq_n),
    .pf_q(pf_q), .af_q(af_q), .uf_q(uf_q)
);

// File: tb/rtc_alarm_irq_bench.sv
module rtc_alarm_irq_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cur_sec = 8'h00, cur_min = 8'h00, cur_hour = 8'h00;
    logic       upd_done = 1'b0, per_tick = 1'b0;
    logic       en_per = 1'b0, en_alm = 1'b0, en_upd = 1'b0;
    logic       wr_en = 1'b0;
    logic [5:0] wr_idx = '0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [5:0] rd_idx = '0;
    logic [7:0] rd_data;
    logic       irq_n;

    int tests = 0;
    int fails = 0;
    bit cmp_on = 1'b0;

    // behavioural reference state
    bit         m_pf, m_af, m_uf;
    logic [7:0] m_alm [3];
    logic [7:0] m_rd;

    always #10 clk = ~clk;

    rtc_alarm_irq u_rtc_alarm_irq (
        .clk(clk), .rst_n(rst_n), .cur_sec(cur_sec), .cur_min(cur_min),
        .cur_hour(cur_hour), .upd_done(upd_done), .per_tick(per_tick),
        .en_per(en_per), .en_alm(en_alm), .en_upd(en_upd), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_data(wr_data), .rd_en(rd_en), .rd_idx(rd_idx),
        .rd_data(rd_data), .irq_n(irq_n)
    );

    function automatic bit fmatch(logic [7:0] a, logic [7:0] t);
        return (a >= 8'hC0) || (a == t);
    endfunction

    function automatic bit m_irq();
        return (m_pf && en_per) || (m_af && en_alm) || (m_uf && en_upd);
    endfunction

    // reference model, advanced on each rising edge
    always @(posedge clk) begin : model
        logic [7:0] st;
        bit clr, hit;
        if (!rst_n) begin
            m_pf = 0; m_af = 0; m_uf = 0; m_rd = 8'h00;
            for (int i = 0; i < 3; i++) m_alm[i] = 8'h00;
        end else begin
            st  = {m_irq(), m_pf, m_af, m_uf, 4'h0};
            clr = rd_en && (rd_idx == 6'd12);
            hit = fmatch(m_alm[0], cur_sec) && fmatch(m_alm[1], cur_min) && fmatch(m_alm[2], cur_hour);
            if (rd_en) begin
                case (rd_idx)
                    6'd1:    m_rd = m_alm[0];
                    6'd3:    m_rd = m_alm[1];
                    6'd5:    m_rd = m_alm[2];
                    6'd12:   m_rd = st;
                    6'd13:   m_rd = 8'h80;
                    default: m_rd = 8'h00;
                endcase
            end
            m_pf = per_tick || (m_pf && !clr);
            m_af = (upd_done && hit) || (m_af && !clr);
            m_uf = upd_done || (m_uf && !clr);
            if (wr_en) begin
                if (wr_idx == 6'd1) m_alm[0] = wr_data;
                if (wr_idx == 6'd3) m_alm[1] = wr_data;
                if (wr_idx == 6'd5) m_alm[2] = wr_data;
            end
        end
    end

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    // cycle-by-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R7 per-cycle rd_data", rd_data, m_rd);
            chk("R9 per-cycle irq_n", {7'd0, irq_n}, {7'd0, !m_irq()});
        end
    end

    task automatic wr(input logic [5:0] idx, input logic [7:0] d);
        @(negedge clk); wr_en = 1; wr_idx = idx; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(input logic [5:0] idx);
        @(negedge clk); rd_en = 1; rd_idx = idx;
        @(negedge clk); rd_en = 0;
    endtask

    task automatic upd();
        @(negedge clk); upd_done = 1;
        @(negedge clk); upd_done = 0;
    endtask

    task automatic tick();
        @(negedge clk); per_tick = 1;
        @(negedge clk); per_tick = 0;
    endtask

    task automatic set_time(input logic [7:0] h, m, s);
        cur_hour = h; cur_min = m; cur_sec = s;
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        cmp_on = 1;
        chk("R1 reset rd_data", rd_data, 8'h00);
        chk("R1 reset irq_n", {7'd0, irq_n}, 8'h01);
        rd(6'd1); chk("R1 alarm byte after reset", rd_data, 8'h00);

        wr(6'd1, 8'h30); wr(6'd3, 8'h15); wr(6'd5, 8'h08);
        wr(6'd2, 8'h77); wr(6'd12, 8'hFF);
        rd(6'd1); chk("R2 seconds alarm", rd_data, 8'h30);
        rd(6'd3); chk("R2 minutes alarm", rd_data, 8'h15);
        rd(6'd5); chk("R2 hours alarm", rd_data, 8'h08);
        rd(6'd2); chk("R10 unmapped index", rd_data, 8'h00);
        rd(6'd12); chk("R2 status untouched by write", rd_data, 8'h00);

        set_time(8'h08, 8'h15, 8'h30);
        upd();
        rd(6'd12); chk("R3 full match", rd_data, 8'h30);
        rd(6'd12); chk("R8 cleared after read", rd_data, 8'h00);

        set_time(8'h08, 8'h15, 8'h31);
        upd();
        rd(6'd12); chk("R5 seconds mismatch", rd_data, 8'h10);

        set_time(8'h08, 8'h15, 8'h30);
        repeat (3) @(negedge clk);
        rd(6'd12); chk("R5 match without update", rd_data, 8'h00);

        wr(6'd1, 8'hC0); set_time(8'h08, 8'h15, 8'h07);
        upd();
        rd(6'd12); chk("R4 seconds wildcard", rd_data, 8'h30);

        wr(6'd1, 8'hFF); wr(6'd3, 8'hC3); set_time(8'h08, 8'h42, 8'h59);
        upd();
        rd(6'd12); chk("R4 two wildcards", rd_data, 8'h30);

        wr(6'd1, 8'h80); set_time(8'h08, 8'h42, 8'h00);
        upd();
        rd(6'd12); chk("R4 0x80 is not wildcard", rd_data, 8'h10);

        wr(6'd1, 8'hFF); set_time(8'h09, 8'h42, 8'h59);
        upd();
        rd(6'd12); chk("R5 hours mismatch", rd_data, 8'h10);

        tick();
        rd(6'd12); chk("R6 periodic flag", rd_data, 8'h40);

        en_per = 1;
        tick();
        chk("R9 periodic irq asserted", {7'd0, irq_n}, 8'h00);
        rd(6'd12); chk("R7 status with IRQF", rd_data, 8'hC0);
        chk("R8 irq released after read", {7'd0, irq_n}, 8'h01);
        en_per = 0;

        en_alm = 1; set_time(8'h08, 8'h42, 8'h11);
        upd();
        chk("R9 alarm irq asserted", {7'd0, irq_n}, 8'h00);
        en_alm = 0;
        @(negedge clk);
        chk("R9 disabled alarm flag held", {7'd0, irq_n}, 8'h01);
        en_upd = 1;
        @(negedge clk);
        chk("R9 update irq asserted", {7'd0, irq_n}, 8'h00);
        rd(6'd12); chk("R7 status alarm+update", rd_data, 8'hB0);

        set_time(8'h09, 8'h42, 8'h11);
        @(negedge clk); rd_en = 1; rd_idx = 6'd12; upd_done = 1;
        @(negedge clk); rd_en = 0; upd_done = 0;
        chk("R8 read in event cycle", rd_data, 8'h00);
        rd(6'd12); chk("R8 event kept over clear", rd_data, 8'h90);
        en_upd = 0;

        rd(6'd13); chk("R10 valid register", rd_data, 8'h80);
        rd(6'd40); chk("R10 high unmapped index", rd_data, 8'h00);

        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule